// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Unit

This block keeps, for each of up to four processors, one pending bit for an inter-processor interrupt and one pending bit for an interval-timer interrupt. Each IPI pending bit drives that processor's level-3 interrupt line. Each timer pending bit drives its level-2 interrupt line.

Software reaches the block through a small register port. The shared control register packs three processor masks into one word. A single write can request IPIs, clear IPIs and clear timer interrupts together. Three dedicated registers each take a plain processor mask for one of those actions. A one-cycle tick input from an external timer posts the timer interrupt to every processor.

Setting a bit that is already set has no effect, and clearing a bit that is already clear has no effect. A malformed write does not halt anything. It raises a sticky error flag that can be read back.

Top module: `ipi_timer_intc`

## Requirements
- R1: After reset every IPI pending bit, every timer pending bit and the error flag are 0.
- R2: A write to register select 0 (control) sets the IPI pending bit of processor n when data bit 12+n is 1. The pending bit shows on `irq_ipi_o[n]` (level 3) in the cycle after the write edge.
- R3: In the same control write, data bit 8+n clears processor n's IPI pending bit and data bit 4+n clears its timer pending bit. All three fields act together in one write.
- R4: When one control write both requests and clears the IPI of the same processor, the request wins and the bit ends up set.
- R5: Requesting an IPI that is already pending, or clearing an IPI or timer bit that is not pending, leaves that bit unchanged.
- R6: A cycle with `tick_i` high sets the timer pending bit of every processor, which shows on `irq_tmr_o` (level 2). If a timer clear lands in the same cycle, the tick wins.
- R7: Register select 1 requests IPIs, select 2 clears IPIs and select 3 clears timer bits. Each uses data bits [NCPU-1:0] as the processor mask.
- R8: A dedicated-register write whose mask is all zero sets the sticky error flag. So does a control write with all three mask fields zero and data bit 28 clear. The flag stays set until reset, and the erroneous write changes no pending bit.
- R9: A control write whose only set bit is bit 28 is accepted and changes no state. It does not set the error flag.
- R10: With select 0, `rdata_o` holds the IPI pending bits in [11:8], the timer pending bits in [7:4], `rd_cpu_i` in [1:0] and the error flag in [31], with all other bits 0. Selects 1 to 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register select for write and read |
| wdata_i | input | DW | Write data |
| rd_cpu_i | input | 2 | ID of the processor issuing a read |
| rdata_o | output | DW | Combinational read data |
| tick_i | input | 1 | Timer event, posts timer interrupt to all processors |
| irq_ipi_o | output | NCPU | Level-3 interrupt per processor (IPI pending) |
| irq_tmr_o | output | NCPU | Level-2 interrupt per processor (timer pending) |
| err_o | output | 1 | Sticky error flag |

## Verification
The properties assume that `tick_i` and `wr_en_i` are single-cycle synchronous strobes that are sampled only after the internal reset has been released. They also assume that no field bits above NCPU carry meaning. The stimulus drives every input on the falling edge, and only once the reset synchronizer has let go. It writes to one register per cycle and uses masks no wider than the processor count. It overlaps a tick with a timer clear, and a request with a clear, only in the cycles set aside for the priority requirements.

// File: rtl/ipitmr_pkg.sv
package ipitmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_IPI_SET = 2'd1,
    SEL_IPI_CLR = 2'd2,
    SEL_TMR_CLR = 2'd3
  } sel_e;

  localparam int FIELD_W    = 4;
  localparam int TCLR_LSB   = 4;
  localparam int ICLR_LSB   = 8;
  localparam int ISET_LSB   = 12;
  localparam int IGNORE_BIT = 28;
  localparam int ERR_BIT    = 31;
endpackage

// File: rtl/ipitmr_rst_sync.sv
module ipitmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/ipitmr_wdec.sv
module ipitmr_wdec
  import ipitmr_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            wr_en_i,
  input  logic [1:0]      sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [NCPU-1:0] ipi_set_o,
  output logic [NCPU-1:0] ipi_clr_o,
  output logic [NCPU-1:0] tmr_clr_o,
  output logic            err_o
);
  logic [NCPU-1:0] f_set, f_iclr, f_tclr, f_mask;
  logic            f_ign;

  always_comb begin
    f_set  = wdata_i[ISET_LSB +: NCPU];
    f_iclr = wdata_i[ICLR_LSB +: NCPU];
    f_tclr = wdata_i[TCLR_LSB +: NCPU];
    f_mask = wdata_i[NCPU-1:0];
    f_ign  = wdata_i[IGNORE_BIT];

    ipi_set_o = '0;
    ipi_clr_o = '0;
    tmr_clr_o = '0;
    err_o     = 1'b0;

    if (wr_en_i) begin
      unique case (sel_e'(sel_i))
        SEL_CTRL: begin
          ipi_set_o = f_set;
          ipi_clr_o = f_iclr;
          tmr_clr_o = f_tclr;
          err_o     = ~(|{f_set, f_iclr, f_tclr}) & ~f_ign;
        end
        SEL_IPI_SET: begin
          ipi_set_o = f_mask;
          err_o     = ~(|f_mask);
        end
        SEL_IPI_CLR: begin
          ipi_clr_o = f_mask;
          err_o     = ~(|f_mask);
        end
        SEL_TMR_CLR: begin
          tmr_clr_o = f_mask;
          err_o     = ~(|f_mask);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipitmr_pend_bank.sv
module ipitmr_pend_bank #(
  parameter int NCPU = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCPU-1:0] set_i,
  input  logic [NCPU-1:0] clr_i,
  output logic [NCPU-1:0] pend_o
);
  for (genvar n = 0; n < NCPU; n++) begin : g_bit
    logic bit_q, bit_d, bit_en;

    always_comb begin
      bit_en = set_i[n] | clr_i[n];
      bit_d  = set_i[n];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign pend_o[n] = bit_q;
  end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import ipitmr_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      sel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [1:0]      rd_cpu_i,
  output logic [DW-1:0]   rdata_o,
  input  logic            tick_i,
  output logic [NCPU-1:0] irq_ipi_o,
  output logic [NCPU-1:0] irq_tmr_o,
  output logic            err_o
);
  localparam logic [NCPU-1:0] ALL_CPU = {NCPU{1'b1}};

  logic            rst_core_n;
  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
  logic            wr_err;
  logic            err_q, err_d, err_en;

  ipitmr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_core_n)
  );

  ipitmr_wdec #(.NCPU(NCPU), .DW(DW)) u_dec (
    .wr_en_i   (wr_en_i),
    .sel_i     (sel_i),
    .wdata_i   (wdata_i),
    .ipi_set_o (ipi_set),
    .ipi_clr_o (ipi_clr),
    .tmr_clr_o (tmr_clr),
    .err_o     (wr_err)
  );

  assign tmr_set = tick_i ? ALL_CPU : '0;

  ipitmr_pend_bank #(.NCPU(NCPU)) u_ipi (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .set_i  (ipi_set),
    .clr_i  (ipi_clr),
    .pend_o (irq_ipi_o)
  );

  ipitmr_pend_bank #(.NCPU(NCPU)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .set_i  (tmr_set),
    .clr_i  (tmr_clr),
    .pend_o (irq_tmr_o)
  );

  always_comb begin
    err_en = wr_err;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n)  err_q <= 1'b0;
    else if (err_en)  err_q <= err_d;
  end

  assign err_o = err_q;

  always_comb begin
    rdata_o = '0;
    if (sel_e'(sel_i) == SEL_CTRL) begin
      rdata_o[ICLR_LSB +: NCPU] = irq_ipi_o;
      rdata_o[TCLR_LSB +: NCPU] = irq_tmr_o;
      rdata_o[1:0]              = rd_cpu_i;
      rdata_o[ERR_BIT]          = err_q;
    end
  end
endmodule

// File: rtl/ipi_timer_intc_chk.sv
module ipi_timer_intc_chk #(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic [1:0]      sel_i,
  input logic [DW-1:0]   wdata_i,
  input logic            tick_i,
  input logic [NCPU-1:0] irq_ipi_o,
  input logic [NCPU-1:0] irq_tmr_o,
  input logic            err_o
);
  // R2
  ctrl_req_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && sel_i == 2'd0) |=>
      ((irq_ipi_o & $past(wdata_i[12 +: NCPU])) == $past(wdata_i[12 +: NCPU])));

  // R6
  tick_posts_all_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_i |=> (&irq_tmr_o));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |=> err_o);

  // R8
  zero_mask_keeps_ipi_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && sel_i != 2'd0 && wdata_i[NCPU-1:0] == '0) |=> ($stable(irq_ipi_o) && err_o));

  // R9
  ignore_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && sel_i == 2'd0 && wdata_i == (DW'(1) << 28)) |=>
      ($stable(irq_ipi_o) && !$rose(err_o)));

  // R5
  idle_keeps_ipi_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_i |=> $stable(irq_ipi_o));
endmodule

bind ipi_timer_intc ipi_timer_intc_chk #(.NCPU(NCPU), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_core_n),
  .wr_en_i   (wr_en_i),
  .sel_i     (sel_i),
  .wdata_i   (wdata_i),
  .tick_i    (tick_i),
  .irq_ipi_o (irq_ipi_o),
  .irq_tmr_o (irq_tmr_o),
  .err_o     (err_o)
);

// File: tb/ipi_timer_intc_tb_top.sv
module ipi_timer_intc_tb_top;
  localparam int NCPU = 4;
  localparam int DW   = 32;

  typedef struct {
    string           tag;
    logic [NCPU-1:0] ipi;
    logic [NCPU-1:0] tmr;
    logic            err;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] rd_cpu = 2'd0;
  logic tick = 1'b0;
  logic [DW-1:0] rdata;
  logic [NCPU-1:0] irq_ipi, irq_tmr;
  logic err;

  int checks = 0;
  int errors = 0;
  exp_t sbq[$];
  logic [NCPU-1:0] m_ipi = '0, m_tmr = '0;
  logic m_err = 1'b0;

  always #2 clk = ~clk;

  ipi_timer_intc #(.NCPU(NCPU), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .sel_i(sel),
    .wdata_i(wdata), .rd_cpu_i(rd_cpu), .rdata_o(rdata), .tick_i(tick),
    .irq_ipi_o(irq_ipi), .irq_tmr_o(irq_tmr), .err_o(err)
  );

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (irq_ipi !== e.ipi || irq_tmr !== e.tmr || err !== e.err) begin
        errors++;
        $display("FAIL %s: ipi=%h tmr=%h err=%b expected ipi=%h tmr=%h err=%b",
                 e.tag, irq_ipi, irq_tmr, err, e.ipi, e.tmr, e.err);
      end
    end
  end

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.ipi = m_ipi; e.tmr = m_tmr; e.err = m_err;
    sbq.push_back(e);
  endtask

  task automatic drive(input logic we, input logic [1:0] s,
                       input logic [DW-1:0] d, input logic tk, input string tag);
    logic [NCPU-1:0] st, ci, ct, mk;
    @(negedge clk);
    wr_en = we; sel = s; wdata = d; tick = tk;
    @(posedge clk);
    #1;
    st = '0; ci = '0; ct = '0; mk = d[NCPU-1:0];
    if (we) begin
      case (s)
        2'd0: begin
          st = d[12 +: NCPU]; ci = d[8 +: NCPU]; ct = d[4 +: NCPU];
          if (st == '0 && ci == '0 && ct == '0 && !d[28]) m_err = 1'b1;
        end
        2'd1: begin st = mk; if (mk == '0) m_err = 1'b1; end
        2'd2: begin ci = mk; if (mk == '0) m_err = 1'b1; end
        default: begin ct = mk; if (mk == '0) m_err = 1'b1; end
      endcase
    end
    m_ipi = (m_ipi & ~ci) | st;
    m_tmr = (m_tmr & ~ct) | (tk ? {NCPU{1'b1}} : '0);
    push(tag);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] s, input logic [1:0] cpu,
                          input string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; sel = s; rd_cpu = cpu;
    #1;
    exp = '0;
    if (s == 2'd0) begin
      exp[8 +: NCPU] = m_ipi; exp[4 +: NCPU] = m_tmr;
      exp[1:0] = cpu; exp[31] = m_err;
    end
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_ipi = '0; m_tmr = '0; m_err = 1'b0;
  endtask

  initial begin
    fork
      begin
        do_reset();
        drive(1'b0, 2'd0, '0, 1'b0, "R1 reset state");
        rd_check(2'd0, 2'd1, "R10 read after reset");
        drive(1'b1, 2'd0, 32'h0000_5000, 1'b0, "R2 control request");
        drive(1'b1, 2'd0, 32'h0000_5000, 1'b0, "R5 repeat request");
        drive(1'b1, 2'd0, 32'h0000_0A00, 1'b0, "R5 clear not pending");
        drive(1'b0, 2'd0, '0, 1'b1, "R6 tick posts all");
        drive(1'b1, 2'd0, 32'h0000_2130, 1'b0, "R3 combined fields");
        drive(1'b1, 2'd0, 32'h0000_8800, 1'b0, "R4 request beats clear");
        rd_check(2'd0, 2'd2, "R10 control read format");
        rd_check(2'd1, 2'd2, "R10 dedicated reads zero");
        drive(1'b1, 2'd1, 32'h1, 1'b0, "R7 dedicated request");
        drive(1'b1, 2'd2, 32'h6, 1'b0, "R7 dedicated ipi clear");
        drive(1'b1, 2'd3, 32'h4, 1'b0, "R7 dedicated timer clear");
        drive(1'b1, 2'd3, 32'h8, 1'b1, "R6 tick beats timer clear");
        drive(1'b1, 2'd0, 32'h1000_0000, 1'b0, "R9 ignored write");
        drive(1'b1, 2'd0, 32'h0000_0000, 1'b0, "R8 empty control write");
        drive(1'b1, 2'd2, 32'h0000_00F0, 1'b0, "R8 zero mask clear");
        drive(1'b1, 2'd1, 32'h2, 1'b0, "R8 flag stays set");
        rd_check(2'd0, 2'd3, "R8 R10 error bit readable");
        do_reset();
        drive(1'b0, 2'd0, '0, 1'b0, "R8 R1 flag cleared by reset");
        @(negedge clk);
        @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule